// File: doc/BRIEF.md
# Variable-Length Tape Record Framer

This block converts between record-level traffic and the flat byte stream of a tape image. The write side takes a command that carries a record length and then takes that many payload bytes. It emits a framed record on a valid/ready byte output: a 32-bit length word, the payload, an optional filler byte, and the same length word again. A command whose length is zero produces a file mark, which is a single zero length word with nothing after it.

The read side parses a framed byte stream from a valid/ready input. It returns each record's payload on a valid/ready output and marks the final byte. When the trailing length word has been consumed, it reports the record length and whether the trailer matched the header. It also pulses a file-mark indication for every zero-length header. It raises an end-of-tape indication together with that pulse when the item just before was also a file mark. The two directions are independent, so a bench or a system can loop one into the other.

Top module: `tape_framer`

## Requirements
- R1: After reset the writer accepts a command (wr_cmd_ready_o high), tx_valid_o and rec_valid_o are low while no payload is offered, and rd_done_o, rd_mark_o and rd_eot_o are low.
- R2: A written record starts with four length bytes, least-significant byte first, equal to the commanded length, and a stalled length byte holds its value.
- R3: The payload bytes follow in arrival order, then the same four length bytes are repeated as a trailer, LSB first.
- R4: When the length is odd, exactly one filler byte of value 0x00 sits between the last payload byte and the trailer; even lengths have none.
- R5: A command with length zero emits exactly four 0x00 bytes (a file mark) and no payload or trailer.
- R6: The reader delivers exactly the payload bytes, in order, on rec_data_o, with rec_last_o high on the final byte only; the filler byte never appears.
- R7: rd_done_o pulses for one cycle once per parsed record, after the trailer, with rd_len_o equal to the leading length.
- R8: rd_err_o is 1 with rd_done_o when the trailing length differs from the leading length, and 0 when they match.
- R9: A zero header pulses rd_mark_o; rd_eot_o is high in that same cycle only when the previous parsed item was also a file mark; a data record in between clears this.
- R10: Reset clears the file-mark history, so the first mark after reset never raises rd_eot_o.
- R11: While rec_ready_i is low during a payload, rx_ready_o is low and no byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_cmd_valid_i | input | 1 | Write command offered |
| wr_cmd_ready_o | output | 1 | Write command accepted |
| wr_cmd_len_i | input | LEN_W | Record length in bytes, zero for a file mark |
| wr_dat_valid_i | input | 1 | Payload byte offered to writer |
| wr_dat_ready_o | output | 1 | Payload byte accepted by writer |
| wr_dat_i | input | 8 | Payload byte to write |
| tx_valid_o | output | 1 | Framed byte valid |
| tx_ready_i | input | 1 | Framed byte taken downstream |
| tx_data_o | output | 8 | Framed byte |
| rx_valid_i | input | 1 | Framed byte offered to reader |
| rx_ready_o | output | 1 | Framed byte accepted by reader |
| rx_data_i | input | 8 | Framed byte to parse |
| rec_valid_o | output | 1 | Parsed payload byte valid |
| rec_ready_i | input | 1 | Parsed payload byte taken |
| rec_data_o | output | 8 | Parsed payload byte |
| rec_last_o | output | 1 | Final payload byte of the record |
| rd_done_o | output | 1 | One-cycle pulse at end of a parsed record |
| rd_len_o | output | LEN_W | Leading length of the last record |
| rd_err_o | output | 1 | Trailer mismatch for the last record |
| rd_mark_o | output | 1 | One-cycle pulse on a zero-length header |
| rd_eot_o | output | 1 | End of tape, with rd_mark_o |

## Verification
A table of records walks lengths 1, 2, 4, 5, 8 and 13 through the writer, which is looped into the reader. Odd and even lengths separate the filler-byte cases, and length 1 exercises a payload that is both first and last byte. Two of the entries throttle the payload consumer every other cycle, so lost or repeated bytes under backpressure become visible. Directed sequences follow. Back-to-back file marks separate a plain mark from end of tape, and a record between marks clears the history. A hand-built frame with a wrong trailer must set the error flag and drop its filler. A reset between two marks must suppress end of tape.

// File: rtl/tape_framer_pkg.sv
package tape_framer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_BODY,
    PH_PAD,
    PH_TRL
  } phase_e;
endpackage

// File: rtl/tape_frame_writer.sv
module tape_frame_writer
  import tape_framer_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             dat_valid_i,
  output logic             dat_ready_o,
  input  logic [7:0]       dat_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o
);
  localparam int LB = LEN_W / 8;
  localparam int IW = (LB > 1) ? $clog2(LB) : 1;

  phase_e           ph_q;
  logic [LEN_W-1:0] len_q, rem_q;
  logic [IW-1:0]    idx_q;
  logic             tx_fire, idx_last;
  logic [7:0]       len_byte;

  assign idx_last = (idx_q == IW'(LB - 1));
  assign len_byte = len_q[8*idx_q +: 8];
  assign tx_fire  = tx_valid_o && tx_ready_i;

  always_comb begin
    cmd_ready_o = (ph_q == PH_IDLE);
    tx_valid_o  = 1'b0;
    tx_data_o   = 8'h00;
    dat_ready_o = 1'b0;
    case (ph_q)
      PH_HDR, PH_TRL: begin
        tx_valid_o = 1'b1;
        tx_data_o  = len_byte;
      end
      PH_PAD: tx_valid_o = 1'b1;
      PH_BODY: begin
        tx_valid_o  = dat_valid_i;
        tx_data_o   = dat_i;
        dat_ready_o = tx_ready_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      len_q <= '0;
      rem_q <= '0;
      idx_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (cmd_valid_i) begin
          len_q <= cmd_len_i;
          rem_q <= cmd_len_i;
          idx_q <= '0;
          ph_q  <= PH_HDR;
        end
        PH_HDR: if (tx_fire) begin
          idx_q <= idx_q + 1'b1;
          if (idx_last) begin
            idx_q <= '0;
            ph_q  <= (len_q == '0) ? PH_IDLE : PH_BODY;
          end
        end
        PH_BODY: if (tx_fire) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) ph_q <= len_q[0] ? PH_PAD : PH_TRL;
        end
        PH_PAD: if (tx_fire) ph_q <= PH_TRL;
        PH_TRL: if (tx_fire) begin
          idx_q <= idx_q + 1'b1;
          if (idx_last) begin
            idx_q <= '0;
            ph_q  <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_len_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && ph_q != PH_BODY) |=> (tx_valid_o && $stable(tx_data_o)));

  assert_mark_no_body_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HDR && len_q == '0) |=> (ph_q != PH_BODY));

  assert_pad_after_odd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_BODY && tx_fire && rem_q == LEN_W'(1) && len_q[0]) |=> (ph_q == PH_PAD));
endmodule

// File: rtl/tape_frame_reader.sv
module tape_frame_reader
  import tape_framer_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [7:0]       rx_data_i,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic [7:0]       rec_data_o,
  output logic             rec_last_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o,
  output logic             err_o,
  output logic             mark_o,
  output logic             eot_o
);
  localparam int LB = LEN_W / 8;
  localparam int IW = (LB > 1) ? $clog2(LB) : 1;

  phase_e           ph_q;
  logic [LEN_W-1:0] word_q, word_nxt, len_q, rem_q;
  logic [IW-1:0]    idx_q;
  logic             prev_mark_q, mark_q, eot_q, done_q, err_q;
  logic             rx_fire, idx_last;

  assign idx_last = (idx_q == IW'(LB - 1));
  assign word_nxt = (word_q >> 8) | (LEN_W'(rx_data_i) << (LEN_W - 8));
  assign rx_fire  = rx_valid_i && rx_ready_o;

  always_comb begin
    case (ph_q)
      PH_BODY:                rx_ready_o = rec_ready_i;
      PH_HDR, PH_PAD, PH_TRL: rx_ready_o = 1'b1;
      default:                rx_ready_o = 1'b0;
    endcase
  end

  assign rec_valid_o = (ph_q == PH_BODY) && rx_valid_i;
  assign rec_data_o  = rx_data_i;
  assign rec_last_o  = (rem_q == LEN_W'(1));
  assign done_o      = done_q;
  assign len_o       = len_q;
  assign err_o       = err_q;
  assign mark_o      = mark_q;
  assign eot_o       = eot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_HDR;
      word_q      <= '0;
      len_q       <= '0;
      rem_q       <= '0;
      idx_q       <= '0;
      prev_mark_q <= 1'b0;
      mark_q      <= 1'b0;
      eot_q       <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      mark_q <= 1'b0;
      eot_q  <= 1'b0;
      done_q <= 1'b0;
      case (ph_q)
        PH_HDR: if (rx_fire) begin
          word_q <= word_nxt;
          idx_q  <= idx_q + 1'b1;
          if (idx_last) begin
            idx_q <= '0;
            if (word_nxt == '0) begin
              mark_q      <= 1'b1;
              eot_q       <= prev_mark_q;
              prev_mark_q <= 1'b1;
            end else begin
              len_q       <= word_nxt;
              rem_q       <= word_nxt;
              prev_mark_q <= 1'b0;
              ph_q        <= PH_BODY;
            end
          end
        end
        PH_BODY: if (rx_fire) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) ph_q <= len_q[0] ? PH_PAD : PH_TRL;
        end
        PH_PAD: if (rx_fire) ph_q <= PH_TRL;
        PH_TRL: if (rx_fire) begin
          word_q <= word_nxt;
          idx_q  <= idx_q + 1'b1;
          if (idx_last) begin
            idx_q  <= '0;
            done_q <= 1'b1;
            err_q  <= (word_nxt != len_q);
            ph_q   <= PH_HDR;
          end
        end
        default: ph_q <= PH_HDR;
      endcase
    end
  end

  assert_eot_with_mark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_o |-> mark_o);

  assert_mark_done_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mark_o && done_o));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_body_backpressure_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |-> !rx_ready_o);
endmodule

// File: rtl/tape_framer.sv
module tape_framer
  import tape_framer_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_valid_i,
  output logic             wr_cmd_ready_o,
  input  logic [LEN_W-1:0] wr_cmd_len_i,
  input  logic             wr_dat_valid_i,
  output logic             wr_dat_ready_o,
  input  logic [7:0]       wr_dat_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [7:0]       rx_data_i,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic [7:0]       rec_data_o,
  output logic             rec_last_o,
  output logic             rd_done_o,
  output logic [LEN_W-1:0] rd_len_o,
  output logic             rd_err_o,
  output logic             rd_mark_o,
  output logic             rd_eot_o
);
  tape_frame_writer #(.LEN_W(LEN_W)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (wr_cmd_valid_i),
    .cmd_ready_o (wr_cmd_ready_o),
    .cmd_len_i   (wr_cmd_len_i),
    .dat_valid_i (wr_dat_valid_i),
    .dat_ready_o (wr_dat_ready_o),
    .dat_i       (wr_dat_i),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_data_o   (tx_data_o)
  );

  tape_frame_reader #(.LEN_W(LEN_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_ready_o  (rx_ready_o),
    .rx_data_i   (rx_data_i),
    .rec_valid_o (rec_valid_o),
    .rec_ready_i (rec_ready_i),
    .rec_data_o  (rec_data_o),
    .rec_last_o  (rec_last_o),
    .done_o      (rd_done_o),
    .len_o       (rd_len_o),
    .err_o       (rd_err_o),
    .mark_o      (rd_mark_o),
    .eot_o       (rd_eot_o)
  );
endmodule

// File: tb/sim_tape_framer.sv
module sim_tape_framer;
  localparam int NREC = 6;
  localparam int REC_LEN   [NREC] = '{1, 4, 5, 8, 13, 2};
  localparam int REC_FRM   [NREC] = '{10, 12, 14, 16, 22, 10};
  localparam bit REC_STALL [NREC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        wr_cmd_valid = 1'b0, wr_dat_valid = 1'b0;
  logic [31:0] wr_cmd_len = '0;
  logic [7:0]  wr_dat = '0;
  logic        inject = 1'b0, inj_valid = 1'b0;
  logic [7:0]  inj_data = '0;
  logic        rec_ready = 1'b1, stall_en = 1'b0;

  logic        wr_cmd_ready, wr_dat_ready, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data, rec_data;
  logic        rec_valid, rec_last, rd_done, rd_err, rd_mark, rd_eot;
  logic [31:0] rd_len;

  assign rx_valid = inject ? inj_valid : tx_valid;
  assign rx_data  = inject ? inj_data  : tx_data;
  assign tx_ready = inject ? 1'b1      : rx_ready;

  tape_framer u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_cmd_valid_i(wr_cmd_valid), .wr_cmd_ready_o(wr_cmd_ready), .wr_cmd_len_i(wr_cmd_len),
    .wr_dat_valid_i(wr_dat_valid), .wr_dat_ready_o(wr_dat_ready), .wr_dat_i(wr_dat),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_data_o(rec_data), .rec_last_o(rec_last),
    .rd_done_o(rd_done), .rd_len_o(rd_len), .rd_err_o(rd_err),
    .rd_mark_o(rd_mark), .rd_eot_o(rd_eot)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] txq [256];
  logic [7:0] rxq [256];
  int tx_n = 0, rx_n = 0, done_n = 0, mark_n = 0, eot_n = 0, last_n = 0, last_pos = 0;
  logic [31:0] seen_len = '0;
  logic seen_err = 1'b0;

  always @(negedge clk) begin
    if (tx_valid && tx_ready && !inject) begin
      if (tx_n < 256) txq[tx_n] = tx_data;
      tx_n++;
    end
    if (rec_valid && rec_ready) begin
      if (rec_last) begin last_n++; last_pos = rx_n; end
      if (rx_n < 256) rxq[rx_n] = rec_data;
      rx_n++;
    end
    if (rd_done) begin done_n++; seen_len = rd_len; seen_err = rd_err; end
    if (rd_mark) mark_n++;
    if (rd_eot) eot_n++;
  end

  initial forever begin
    @(posedge clk); #1;
    rec_ready = stall_en ? ~rec_ready : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_cmd(input int len);
    bit ok;
    wr_cmd_valid = 1'b1;
    wr_cmd_len   = 32'(len);
    do begin
      @(negedge clk); ok = wr_cmd_ready;
      @(posedge clk); #1;
    end while (!ok);
    wr_cmd_valid = 1'b0;
  endtask

  task automatic send_dat(input logic [7:0] b);
    bit ok;
    wr_dat_valid = 1'b1;
    wr_dat       = b;
    do begin
      @(negedge clk); ok = wr_dat_ready;
      @(posedge clk); #1;
    end while (!ok);
    wr_dat_valid = 1'b0;
  endtask

  task automatic send_raw(input logic [7:0] b);
    bit ok;
    inj_valid = 1'b1;
    inj_data  = b;
    do begin
      @(negedge clk); ok = rx_ready;
      @(posedge clk); #1;
    end while (!ok);
    inj_valid = 1'b0;
  endtask

  function automatic logic [7:0] frame_byte(input int len, input int seed, input int k);
    int pad, off;
    pad = len & 1;
    if (k < 4) return 8'(len >> (8 * k));
    if (k < 4 + len) return 8'(seed + k - 4);
    if (pad == 1 && k == 4 + len) return 8'h00;
    off = k - 4 - len - pad;
    return 8'(len >> (8 * off));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int b_tx, b_rx, b_dn, b_mk, b_eo, b_ls, bad_h, bad_p, bad_pad, bad_t, bad_r;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    @(negedge clk);
    // R1: state after reset
    chk(wr_cmd_ready == 1'b1, "R1 cmd_ready", int'(wr_cmd_ready), 1);
    chk(tx_valid == 1'b0 && rec_valid == 1'b0, "R1 valids", int'({tx_valid, rec_valid}), 0);
    chk({rd_done, rd_mark, rd_eot} == 3'b000, "R1 pulses", int'({rd_done, rd_mark, rd_eot}), 0);
    @(posedge clk); #1;

    for (int r = 0; r < NREC; r++) begin
      int len, seed;
      len = REC_LEN[r];
      seed = 37 * r + 5;
      stall_en = REC_STALL[r];
      b_tx = tx_n; b_rx = rx_n; b_dn = done_n; b_ls = last_n;
      send_cmd(len);
      for (int i = 0; i < len; i++) send_dat(8'(seed + i));
      cyc(12);
      stall_en = 1'b0;
      bad_h = 0; bad_p = 0; bad_pad = 0; bad_t = 0; bad_r = 0;
      for (int k = 0; k < REC_FRM[r]; k++) begin
        if (b_tx + k < 256 && txq[b_tx + k] !== frame_byte(len, seed, k)) begin
          if (k < 4) bad_h++;
          else if (k < 4 + len) bad_p++;
          else if (k < REC_FRM[r] - 4) bad_pad++;
          else bad_t++;
        end
      end
      for (int i = 0; i < len; i++)
        if (b_rx + i < 256 && rxq[b_rx + i] !== 8'(seed + i)) bad_r++;
      chk(tx_n - b_tx == REC_FRM[r], "R4 frame size", tx_n - b_tx, REC_FRM[r]);
      chk(bad_h == 0, "R2 header bytes", bad_h, 0);
      chk(bad_p == 0 && bad_t == 0, "R3 payload/trailer", bad_p + bad_t, 0);
      chk(bad_pad == 0, "R4 pad byte", bad_pad, 0);
      chk(rx_n - b_rx == len, REC_STALL[r] ? "R11 rx count" : "R6 rx count", rx_n - b_rx, len);
      chk(bad_r == 0, REC_STALL[r] ? "R11 rx data" : "R6 rx data", bad_r, 0);
      chk(last_n - b_ls == 1 && last_pos == b_rx + len - 1, "R6 last flag", last_pos - b_rx, len - 1);
      chk(done_n - b_dn == 1, "R7 done count", done_n - b_dn, 1);
      chk(seen_len == 32'(len) && seen_err == 1'b0, "R7 done len", int'(seen_len), len);
    end

    // R5/R9: mark after a data record, then a second mark
    b_tx = tx_n; b_mk = mark_n; b_eo = eot_n;
    send_cmd(0);
    cyc(6);
    chk(tx_n - b_tx == 4, "R5 mark size", tx_n - b_tx, 4);
    chk({txq[b_tx], txq[b_tx+1], txq[b_tx+2], txq[b_tx+3]} == 32'h0, "R5 mark bytes",
        int'({txq[b_tx], txq[b_tx+1], txq[b_tx+2], txq[b_tx+3]}), 0);
    chk(mark_n - b_mk == 1 && eot_n == b_eo, "R9 first mark no eot", eot_n - b_eo, 0);
    send_cmd(0);
    cyc(6);
    chk(mark_n - b_mk == 2 && eot_n - b_eo == 1, "R9 second mark eot", eot_n - b_eo, 1);

    // R8: hand-built frame with mismatched trailer, odd length
    inject = 1'b1;
    b_rx = rx_n; b_dn = done_n; b_eo = eot_n; b_mk = mark_n;
    send_raw(8'h03); send_raw(8'h00); send_raw(8'h00); send_raw(8'h00);
    send_raw(8'hAA); send_raw(8'hBB); send_raw(8'hCC); send_raw(8'h55);
    send_raw(8'h04); send_raw(8'h00); send_raw(8'h00); send_raw(8'h00);
    cyc(3);
    chk(done_n - b_dn == 1 && seen_err == 1'b1, "R8 trailer mismatch", int'(seen_err), 1);
    chk(seen_len == 32'd3, "R7 len on error frame", int'(seen_len), 3);
    chk(rx_n - b_rx == 3 && rxq[b_rx + 2] == 8'hCC, "R6 pad dropped", rx_n - b_rx, 3);
    // data record between marks clears history
    send_raw(8'h00); send_raw(8'h00); send_raw(8'h00); send_raw(8'h00);
    cyc(3);
    chk(mark_n - b_mk == 1 && eot_n == b_eo, "R9 record clears history", eot_n - b_eo, 0);

    // R10: reset between two marks
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(2);
    b_mk = mark_n; b_eo = eot_n;
    send_raw(8'h00); send_raw(8'h00); send_raw(8'h00); send_raw(8'h00);
    cyc(3);
    chk(mark_n - b_mk == 1 && eot_n == b_eo, "R10 no eot after reset", eot_n - b_eo, 0);
    inject = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule